// File: doc/BRIEF.md
# Interrupt vector ring writer

This block sits between the on-chip interrupt sources and system memory. Every interrupt event a source hands over is turned into a 16-byte record of four 32-bit words. The block writes that record into a circular buffer that the host has set aside in memory. Both ring pointers count bytes. The block owns the write pointer. The host moves the read pointer through a register once it has consumed entries, and the ring counts as empty whenever the two pointers match.

Incoming events wait in a small queue while a record is being written out. Each word leaves through a simple request/acknowledge memory-write port. Optionally, the new write-pointer value is then copied to a second memory location that the host can poll instead of reading a register. If the writer advances onto the host's read position, it does not stop. It sets a sticky overflow flag in bit 0 of the write-pointer value, which software clears through a control bit. The interrupt line to the host works in one of two ways: as a level that is high while entries are pending, or, in re-arm mode, as one-cycle pulses.

Software programs the block through a small word-indexed register port. The ring base is held as address bits [39:8]. The ring length is set as the base-2 log of its size in 32-bit words, and at least 3 is needed so the ring holds two or more records.

Top module: `ivr_writer`

## Requirements
- R1: Each vector is issued as four word writes, in the order word 0 to word 3, at addresses ring_base + wptr + 0, 4, 8 and 12. Here ring_base = {BASE register, 8'h00}.
- R2: The words are laid out as follows. Word 0 holds the source id in [7:0] and zeros above it. Word 1 holds the 28-bit source data in [27:0] and zeros above it. Word 2 holds the ring id in [7:0], the VM id in [15:8] and the address-space id in [31:16]. Word 3 is zero.
- R3: After each vector the write pointer advances by 16. It wraps with the mask (4 << size) - 1, where size is CTRL[9:5].
- R4: If the advanced write pointer equals the read pointer, bit 0 of the write-pointer word (register offset 5) becomes 1. The bit stays set across later vectors and clears only when 1 is written to CTRL bit 4. That control bit always reads back as 0.
- R5: With CTRL bit 2 set, each vector is followed by a fifth write of the new write-pointer word. Its address is {WBHI[7:0], WBLO[31:2], 2'b00}. WBHI (offset 3) keeps only 8 bits and WBLO (offset 2) drops bits [1:0].
- R6: While CTRL bit 0 (ring enable) is 0, no new vector is started. Up to 4 events are held, and ev_ready is low while the 4 are held. Setting the enable bit again drains the held events in arrival order.
- R7: Writes to RPTR (offset 4) and WPTR (offset 5) load the pointer with the written value ANDed with the ring mask, with bits [3:0] cleared.
- R8: With CTRL bit 1 (interrupt enable) set and CTRL bit 3 (re-arm) clear, irq_out is high exactly while the write and read pointers differ, delayed by one register stage. With CTRL bit 1 clear, irq_out is low.
- R9: In re-arm mode, irq_out gives a one-cycle pulse for each completed vector. It also pulses after a host RPTR write that leaves the read pointer different from the write pointer. At all other times it is low.
- R10: busy is high while an event is queued or a vector or writeback write is in progress.
- R11: While mem_req is high and mem_ack is low, mem_req, mem_addr and mem_data hold their values.
- R12: After reset all control fields and both pointers are 0. irq_out, busy and mem_req are low, and ev_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Interrupt event offered |
| ev_ready | output | 1 | Event queue has room |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vmid | input | 8 | VM id |
| ev_pasid | input | 16 | Address-space id |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index: 0 CTRL, 1 BASE, 2 WBLO, 3 WBHI, 4 RPTR, 5 WPTR |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_re |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 40 | Byte address of the word written |
| mem_data | output | 32 | Word written |
| mem_ack | input | 1 | Memory accepts the current word |
| irq_out | output | 1 | Interrupt to the host |
| busy | output | 1 | Queue non-empty or write in flight |

## Verification
The bench drives the write pointer all the way around the ring until it lands on the read pointer. A design that compares the pointers before advancing, or that forgets the wrap mask, would flag overflow at the wrong record or write past the end of the ring. It then checks that the flag survives another vector and clears only through the control bit, which exposes a flag that self-clears or is recomputed each time. Disabling the ring with four events queued tests back-pressure and the drain order after re-enable. A stalled memory acknowledge tests that the request holds steady, since a design that advanced too early would skip or repeat words. Re-arm pulses are counted, including after a read-pointer write that leaves nothing pending, where a design that pulsed on every write would produce one pulse too many.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

  localparam int ADDR_W    = 40;
  localparam int DATA_W    = 32;
  localparam int VEC_BYTES = 16;
  localparam int RA_W      = 3;

  localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
  localparam logic [RA_W-1:0] RA_BASE = 3'd1;
  localparam logic [RA_W-1:0] RA_WBLO = 3'd2;
  localparam logic [RA_W-1:0] RA_WBHI = 3'd3;
  localparam logic [RA_W-1:0] RA_RPTR = 3'd4;
  localparam logic [RA_W-1:0] RA_WPTR = 3'd5;

  localparam int CB_RING  = 0;
  localparam int CB_INTR  = 1;
  localparam int CB_WB    = 2;
  localparam int CB_REARM = 3;
  localparam int CB_CLR   = 4;
  localparam int CB_SIZE  = 5;
  localparam int SIZE_W   = 5;

  typedef struct packed {
    logic [15:0] pasid;
    logic [7:0]  vmid;
    logic [7:0]  ring;
    logic [27:0] data;
    logic [7:0]  src;
  } ivr_vec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_VEC, ST_WB} ivr_state_e;

  function automatic logic [DATA_W-1:0] ivr_word(ivr_vec_t v, logic [1:0] idx);
    logic [DATA_W-1:0] w;
    case (idx)
      2'd0:    w = {24'h0, v.src};
      2'd1:    w = {4'h0, v.data};
      2'd2:    w = {v.pasid, v.vmid, v.ring};
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/ivr_event_fifo.sv
module ivr_event_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 68
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6: occupancy never exceeds capacity; a full queue refuses a lone push
  a_r6_cap: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH));
  a_r6_full_hold: assert property (@(posedge clk) disable iff (rst)
    full && !pop |=> full);

endmodule

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PTR_W-1:0]  wptr_in,
  input  logic              ovf_in,
  output logic              ring_en,
  output logic              intr_en,
  output logic              wb_en,
  output logic              rearm_en,
  output logic [PTR_W-1:0]  ring_mask,
  output logic [ADDR_W-1:0] ring_base,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [PTR_W-1:0]  rptr,
  output logic              rptr_wr,
  output logic              sw_wptr_we,
  output logic [PTR_W-1:0]  sw_wptr_val,
  output logic              ovf_clr
);
  logic              ring_q, intr_q, wb_q, rearm_q;
  logic [SIZE_W-1:0] size_q;
  logic [31:0]       base_q;
  logic [29:0]       wb_lo_q;
  logic [7:0]        wb_hi_q;
  logic [PTR_W-1:0]  rptr_q;
  logic [PTR_W-1:0]  one_sh, mask_c, ptr_val;

  always_comb begin
    one_sh  = {{(PTR_W-1){1'b0}}, 1'b1} << ({1'b0, size_q} + 6'd2);
    mask_c  = one_sh - PTR_W'(1);
    ptr_val = reg_wdata[PTR_W-1:0] & mask_c & ~PTR_W'(15);
  end

  assign ring_en     = ring_q;
  assign intr_en     = intr_q;
  assign wb_en       = wb_q;
  assign rearm_en    = rearm_q;
  assign ring_mask   = mask_c;
  assign ring_base   = {base_q, 8'h00};
  assign wb_addr     = {wb_hi_q, wb_lo_q, 2'b00};
  assign rptr        = rptr_q;
  assign rptr_wr     = reg_we && (reg_addr == RA_RPTR);
  assign sw_wptr_we  = reg_we && (reg_addr == RA_WPTR);
  assign sw_wptr_val = ptr_val;
  assign ovf_clr     = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q  <= 1'b0;
      intr_q  <= 1'b0;
      wb_q    <= 1'b0;
      rearm_q <= 1'b0;
      size_q  <= '0;
      base_q  <= '0;
      wb_lo_q <= '0;
      wb_hi_q <= '0;
      rptr_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_CTRL: begin
          ring_q  <= reg_wdata[CB_RING];
          intr_q  <= reg_wdata[CB_INTR];
          wb_q    <= reg_wdata[CB_WB];
          rearm_q <= reg_wdata[CB_REARM];
          size_q  <= reg_wdata[CB_SIZE +: SIZE_W];
        end
        RA_BASE: base_q  <= reg_wdata;
        RA_WBLO: wb_lo_q <= reg_wdata[31:2];
        RA_WBHI: wb_hi_q <= reg_wdata[7:0];
        RA_RPTR: rptr_q  <= ptr_val;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        RA_CTRL: reg_rdata <= 32'({size_q, 1'b0, rearm_q, wb_q, intr_q, ring_q});
        RA_BASE: reg_rdata <= base_q;
        RA_WBLO: reg_rdata <= {wb_lo_q, 2'b00};
        RA_WBHI: reg_rdata <= 32'(wb_hi_q);
        RA_RPTR: reg_rdata <= 32'(rptr_q);
        RA_WPTR: reg_rdata <= 32'(wptr_in) | 32'(ovf_in);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R7: the host read pointer always lands on a record boundary
  a_r7_rptr_aligned: assert property (@(posedge clk) disable iff (rst)
    rptr_q[3:0] == 4'h0);

endmodule

// File: rtl/ivr_ptr_unit.sv
module ivr_ptr_unit
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic             sw_we,
  input  logic [PTR_W-1:0] sw_val,
  input  logic             ovf_clr,
  input  logic [PTR_W-1:0] ring_mask,
  input  logic [PTR_W-1:0] rptr,
  output logic [PTR_W-1:0] wptr,
  output logic             ovf,
  output logic [PTR_W-1:0] wptr_adv,
  output logic             ovf_adv
);
  logic hit;

  always_comb begin
    wptr_adv = (wptr + PTR_W'(VEC_BYTES)) & ring_mask;
    hit      = (wptr_adv == rptr);
    ovf_adv  = (ovf && !ovf_clr) || hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      ovf  <= 1'b0;
    end else begin
      if (sw_we)       wptr <= sw_val;
      else if (commit) wptr <= wptr_adv;
      ovf <= (ovf && !ovf_clr) || (commit && hit);
    end
  end

  // R4: overflow is sticky until cleared, and a clear without a new hit drops it
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf && !ovf_clr |=> ovf);
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    ovf_clr && !commit |=> !ovf);
  // R3: a committed record always moves the pointer when the ring holds two or more
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    commit && !sw_we && ring_mask[4] |=> wptr != $past(wptr));
  a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
    wptr[3:0] == 4'h0);

endmodule

// File: rtl/ivr_wr_engine.sv
module ivr_wr_engine
  import ivr_pkg::*;
#(
  parameter int PTR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring_en,
  input  logic              wb_en,
  input  logic              fifo_empty,
  input  ivr_vec_t          fifo_dout,
  output logic              fifo_pop,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [PTR_W-1:0]  wptr_adv,
  input  logic              ovf_adv,
  output logic              commit,
  output logic              active,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ack
);
  ivr_state_e state;
  logic [1:0] widx;
  ivr_vec_t   vec_q;
  logic       beat_done;

  assign beat_done = mem_req && mem_ack;
  assign fifo_pop  = (state == ST_IDLE) && !fifo_empty && ring_en;
  assign commit    = (state == ST_VEC) && beat_done && (widx == 2'd3);
  assign active    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      widx     <= '0;
      vec_q    <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fifo_pop) begin
            vec_q    <= fifo_dout;
            widx     <= 2'd0;
            mem_req  <= 1'b1;
            mem_addr <= ring_base + ADDR_W'(wptr);
            mem_data <= ivr_word(fifo_dout, 2'd0);
            state    <= ST_VEC;
          end
        end
        ST_VEC: begin
          if (beat_done) begin
            if (widx == 2'd3) begin
              if (wb_en) begin
                mem_addr <= wb_addr;
                mem_data <= DATA_W'(wptr_adv) | DATA_W'(ovf_adv);
                state    <= ST_WB;
              end else begin
                mem_req <= 1'b0;
                state   <= ST_IDLE;
              end
            end else begin
              widx     <= widx + 2'd1;
              mem_addr <= mem_addr + ADDR_W'(4);
              mem_data <= ivr_word(vec_q, widx + 2'd1);
            end
          end
        end
        ST_WB: begin
          if (beat_done) begin
            mem_req <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: begin
          mem_req <= 1'b0;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  // R11: an unacknowledged request holds still
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data));
  // R6: a disabled ring starts nothing new
  a_r6_no_start: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && !ring_en |=> !mem_req);
  // R1: a request exists only while a record or writeback is in flight
  a_r1_req_in_flight: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> state != ST_IDLE);

endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int PTR_W      = 18,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_valid,
  output logic        ev_ready,
  input  logic [7:0]  ev_src,
  input  logic [27:0] ev_data,
  input  logic [7:0]  ev_ring,
  input  logic [7:0]  ev_vmid,
  input  logic [15:0] ev_pasid,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [39:0] mem_addr,
  output logic [31:0] mem_data,
  input  logic        mem_ack,
  output logic        irq_out,
  output logic        busy
);
  localparam int VEC_W = $bits(ivr_vec_t);

  ivr_vec_t          ev_vec, fifo_dout;
  logic              fifo_full, fifo_empty, fifo_pop;
  logic              ring_en, intr_en, wb_en, rearm_en;
  logic [PTR_W-1:0]  ring_mask, rptr, wptr, wptr_adv, sw_wptr_val;
  logic [ADDR_W-1:0] ring_base, wb_addr;
  logic              rptr_wr, sw_wptr_we, ovf_clr, ovf, ovf_adv;
  logic              commit, active;
  logic              rptr_wr_q, irq_q;

  assign ev_vec   = '{pasid: ev_pasid, vmid: ev_vmid, ring: ev_ring, data: ev_data, src: ev_src};
  assign ev_ready = !fifo_full;

  ivr_event_fifo #(.DEPTH(FIFO_DEPTH), .W(VEC_W)) u_fifo (
    .clk(clk), .rst(rst), .push(ev_valid), .din(ev_vec), .pop(fifo_pop),
    .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty)
  );

  ivr_regs #(.PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wptr_in(wptr), .ovf_in(ovf),
    .ring_en(ring_en), .intr_en(intr_en), .wb_en(wb_en), .rearm_en(rearm_en),
    .ring_mask(ring_mask), .ring_base(ring_base), .wb_addr(wb_addr), .rptr(rptr),
    .rptr_wr(rptr_wr), .sw_wptr_we(sw_wptr_we), .sw_wptr_val(sw_wptr_val),
    .ovf_clr(ovf_clr)
  );

  ivr_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .commit(commit), .sw_we(sw_wptr_we), .sw_val(sw_wptr_val),
    .ovf_clr(ovf_clr), .ring_mask(ring_mask), .rptr(rptr), .wptr(wptr), .ovf(ovf),
    .wptr_adv(wptr_adv), .ovf_adv(ovf_adv)
  );

  ivr_wr_engine #(.PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst(rst), .ring_en(ring_en), .wb_en(wb_en), .fifo_empty(fifo_empty),
    .fifo_dout(fifo_dout), .fifo_pop(fifo_pop), .ring_base(ring_base),
    .wb_addr(wb_addr), .wptr(wptr), .wptr_adv(wptr_adv), .ovf_adv(ovf_adv),
    .commit(commit), .active(active), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ack(mem_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_wr_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rptr_wr_q <= rptr_wr;
      if (!intr_en)      irq_q <= 1'b0;
      else if (rearm_en) irq_q <= commit || (rptr_wr_q && (rptr != wptr));
      else               irq_q <= (wptr != rptr);
    end
  end

  assign irq_out = irq_q;
  assign busy    = !fifo_empty || active;

  // R8: interrupts stay quiet while disabled
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !intr_en |=> !irq_out);
  // R10: any memory traffic implies busy
  a_r10_busy_req: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  // R9: re-arm pulses last one cycle
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    rearm_en && irq_out && !commit && !rptr_wr_q |=> !irq_out);

endmodule

// File: tb/ivr_writer_tb.sv
`timescale 1ns/1ps
module ivr_writer_tb_top;
  logic        clk = 1'b0, rst = 1'b1;
  logic        ev_valid = 1'b0, ev_ready;
  logic [7:0]  ev_src = '0, ev_ring = '0, ev_vmid = '0;
  logic [27:0] ev_data = '0;
  logic [15:0] ev_pasid = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_ack = 1'b0;
  logic [39:0] mem_addr;
  logic [31:0] mem_data;
  logic        irq_out, busy;

  int checks = 0, fails = 0;
  logic [39:0] log_addr [64];
  logic [31:0] log_data [64];
  int log_n = 0, ack_delay = 0, wait_cnt = 0, stall_bad = 0, irq_pulses = 0;
  logic [39:0] first_addr;
  logic [31:0] first_data;
  localparam logic [39:0] BASE = 40'h00_0123_4500;
  localparam int SZ = 5;

  always #2.5 clk = ~clk;

  ivr_writer dut_i (.*);

  // memory responder
  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt < ack_delay) begin
        if (wait_cnt == 0) begin first_addr = mem_addr; first_data = mem_data; end
        else if (mem_addr !== first_addr || mem_data !== first_data) stall_bad++;
        wait_cnt++;
      end else begin
        if (log_n < 64) begin log_addr[log_n] = mem_addr; log_data[log_n] = mem_data; end
        log_n++;
        mem_ack = 1'b1;
        wait_cnt = 0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq_out) irq_pulses++;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl(bit ring, bit intr, bit wb, bit rearm, bit clr);
    return 32'(SZ) << 5 | 32'(clr) << 4 | 32'(rearm) << 3 | 32'(wb) << 2 | 32'(intr) << 1 | 32'(ring);
  endfunction

  task automatic send_ev(logic [7:0] s, logic [27:0] d, logic [7:0] r, logic [7:0] v, logic [15:0] p);
    @(negedge clk);
    ev_valid = 1'b1; ev_src = s; ev_data = d; ev_ring = r; ev_vmid = v; ev_pasid = p;
    while (!ev_ready) @(negedge clk);
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R12 irq", 64'(irq_out), 64'd0);
    chk("R12 busy", 64'(busy), 64'd0);
    chk("R12 req", 64'(mem_req), 64'd0);
    chk("R12 ready", 64'(ev_ready), 64'd1);
    reg_read(3'd0, v); chk("R12 ctrl", 64'(v), 64'd0);
    reg_read(3'd5, v); chk("R12 wptr", 64'(v), 64'd0);
    reg_read(3'd4, v); chk("R12 rptr", 64'(v), 64'd0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    reg_write(3'd1, 32'h0001_2345);
    reg_write(3'd0, ctrl(1, 1, 0, 0, 0));
    log_n = 0;
    send_ev(8'hA5, 28'hABC_DEF1, 8'h11, 8'h22, 16'h3344);
    wait_idle();
    chk("R1 count", 64'(log_n), 64'd4);
    for (int i = 0; i < 4; i++) chk("R1 addr", 64'(log_addr[i]), 64'(BASE + 40'(4*i)));
    chk("R2 w0", 64'(log_data[0]), 64'h0000_00A5);
    chk("R2 w1", 64'(log_data[1]), 64'h0ABC_DEF1);
    chk("R2 w2", 64'(log_data[2]), 64'h3344_2211);
    chk("R2 w3", 64'(log_data[3]), 64'h0);
    reg_read(3'd5, v); chk("R3 step", 64'(v), 64'd16);
    chk("R8 level high", 64'(irq_out), 64'd1);
    reg_read(3'd0, v); chk("R4 clr reads 0", 64'(v), 64'(ctrl(1, 1, 0, 0, 0)));
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    reg_write(3'd4, 32'd16);
    repeat (3) @(negedge clk);
    chk("R8 level low", 64'(irq_out), 64'd0);
    log_n = 0;
    for (int i = 0; i < 7; i++) send_ev(8'(i), 28'(i), 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R1 count7", 64'(log_n), 64'd28);
    chk("R3 last addr", 64'(log_addr[27]), 64'(BASE + 40'd124));
    reg_read(3'd5, v); chk("R3 wrap", 64'(v), 64'd0);
    log_n = 0;
    send_ev(8'h1, 28'h1, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R3 wrapped addr", 64'(log_addr[0]), 64'(BASE));
    reg_read(3'd5, v); chk("R4 set", 64'(v), 64'd17);
    send_ev(8'h2, 28'h2, 8'h0, 8'h0, 16'h0);
    wait_idle();
    reg_read(3'd5, v); chk("R4 sticky", 64'(v), 64'd33);
    reg_write(3'd0, ctrl(1, 1, 0, 0, 1));
    reg_read(3'd5, v); chk("R4 cleared", 64'(v), 64'd32);
  endtask

  task automatic t_writeback();
    logic [31:0] v;
    reg_write(3'd2, 32'h0000_8007);
    reg_write(3'd3, 32'h0000_01AB);
    reg_write(3'd0, ctrl(1, 1, 1, 0, 0));
    log_n = 0;
    send_ev(8'h7, 28'h7, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R5 count", 64'(log_n), 64'd5);
    chk("R5 addr", 64'(log_addr[4]), 64'h00AB_0000_8004);
    chk("R5 data", 64'(log_data[4]), 64'd48);
    reg_read(3'd3, v); chk("R5 hi 8 bits", 64'(v), 64'hAB);
    reg_read(3'd2, v); chk("R5 lo aligned", 64'(v), 64'h8004);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    reg_write(3'd0, ctrl(0, 0, 0, 0, 0));
    log_n = 0;
    for (int i = 0; i < 4; i++) send_ev(8'(8'h40 + i), 28'(i), 8'h0, 8'h0, 16'h0);
    repeat (20) @(negedge clk);
    chk("R6 no writes", 64'(log_n), 64'd0);
    chk("R6 ready low when full", 64'(ev_ready), 64'd0);
    chk("R10 busy queued", 64'(busy), 64'd1);
    reg_write(3'd4, 32'd0);
    reg_write(3'd5, 32'd0);
    reg_read(3'd5, v); chk("R7 wptr zeroed", 64'(v), 64'd0);
    reg_write(3'd0, ctrl(1, 0, 0, 0, 0));
    wait_idle();
    chk("R6 drained", 64'(log_n), 64'd16);
    chk("R6 first addr", 64'(log_addr[0]), 64'(BASE));
    chk("R6 order", 64'(log_data[12]), 64'h43);
    chk("R1 last addr", 64'(log_addr[15]), 64'(BASE + 40'd60));
    reg_read(3'd5, v); chk("R3 after drain", 64'(v), 64'd64);
    chk("R10 busy idle", 64'(busy), 64'd0);
    chk("R8 disabled irq", 64'(irq_out), 64'd0);
  endtask

  task automatic t_sw_ptr();
    logic [31:0] v;
    reg_write(3'd4, 32'h25);
    reg_read(3'd4, v); chk("R7 rptr align", 64'(v), 64'h20);
    reg_write(3'd4, 32'h1F5);
    reg_read(3'd4, v); chk("R7 rptr mask", 64'(v), 64'h70);
    reg_write(3'd0, ctrl(1, 1, 0, 0, 0));
    repeat (2) @(negedge clk);
    chk("R8 pending", 64'(irq_out), 64'd1);
    reg_write(3'd4, 32'd64);
    repeat (2) @(negedge clk);
    chk("R8 caught up", 64'(irq_out), 64'd0);
  endtask

  task automatic t_rearm();
    reg_write(3'd0, ctrl(1, 1, 0, 1, 0));
    repeat (2) @(negedge clk);
    irq_pulses = 0;
    send_ev(8'h9, 28'h9, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R9 vector pulse", 64'(irq_pulses), 64'd1);
    reg_write(3'd4, 32'd80);
    repeat (5) @(negedge clk);
    chk("R9 no pulse empty", 64'(irq_pulses), 64'd1);
    reg_write(3'd4, 32'd64);
    repeat (5) @(negedge clk);
    chk("R9 rearm pulse", 64'(irq_pulses), 64'd2);
    chk("R9 not level", 64'(irq_out), 64'd0);
  endtask

  task automatic t_stall();
    reg_write(3'd0, ctrl(1, 0, 0, 0, 0));
    ack_delay = 3; stall_bad = 0; log_n = 0;
    send_ev(8'h5A, 28'h5, 8'h1, 8'h2, 16'h3);
    wait_idle();
    ack_delay = 0;
    chk("R11 stable", 64'(stall_bad), 64'd0);
    chk("R11 count", 64'(log_n), 64'd4);
    chk("R11 addr", 64'(log_addr[3]), 64'(BASE + 40'd92));
    chk("R11 data", 64'(log_data[2]), 64'h0003_0201);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_overflow();
    t_writeback();
    t_disable();
    t_sw_ptr();
    t_rearm();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule